// File: doc/BRIEF.md
# Dual-Band Multi-Modulus Prescaler

This block divides a fast input clock by one of four ratios (32, 33, 47 or 48). It is built as a divide-by-2/3 cell feeding a fixed binary chain of sixteen sub-cycles. A band-select pin picks the low band (32/33) or the high band (47/48). A modulus-control pin then picks one ratio inside that band. The 47/48 pair costs no extra state. One control term decides whether the last sub-cycle "swallows" a different length. In the high band that term is inverted before it reaches the 2/3 cell, so the cell runs divide-by-3 by default and divide-by-2 on the swallow.

The block gives a divided clock and a terminal pulse. The divided clock is high for the first half of the sub-cycles. The terminal pulse lasts one input cycle and marks the final input cycle of each output period. Both are decoded from registered state only. The two selection pins are captured in the final input cycle of each period, and also during reset. A change on them therefore takes effect from the next full period, and a period already running is never disturbed. Control pins are plain levels. No data stream passes through the block, so there is no handshake.

Top module: `dualband_prescaler`

## Requirements
- R1: While `rst` is high (synchronous, active high), all counters are cleared: `div_clk` reads 1 and `term_pulse` reads 0.
- R2: With `band_sel`=0 and `mod_ctl`=1, consecutive terminal pulses are 32 input cycles apart.
- R3: With `band_sel`=0 and `mod_ctl`=0, the period is 33 input cycles: one sub-cycle of three, fifteen of two.
- R4: With `band_sel`=1 and `mod_ctl`=1, the period is 48 input cycles, with every sub-cycle three long.
- R5: With `band_sel`=1 and `mod_ctl`=0, the period is 47 input cycles: fifteen sub-cycles of three and one of two.
- R6: `term_pulse` is high for exactly one input cycle per period, in the period's final input cycle.
- R7: `div_clk` is high for the first half of the sub-cycles of each period: 16 input cycles in the low band and 24 in the high band.
- R8: Changes on `band_sel` or `mod_ctl` before the final input cycle of a period do not alter that period's length.
- R9: The first period after reset is measured from the first cycle with `rst` low. Its length equals the ratio selected while reset was held.
- R10: The levels on `band_sel` and `mod_ctl` during the cycle in which `term_pulse` is high set the ratio of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| band_sel | input | 1 | 0: 32/33 band, 1: 47/48 band |
| mod_ctl | input | 1 | 1: uniform ratio (32 or 48), 0: swallow ratio (33 or 47) |
| div_clk | output | 1 | Divided clock, high for the first half of the sub-cycles |
| term_pulse | output | 1 | One-cycle pulse in the final input cycle of each period |

## Verification
Several events meet in the final input cycle of a period: the terminal pulse, the capture of new band and modulus settings, and the swallow sub-cycle. The bench provokes this by changing the selection pins in exactly the cycle where the terminal pulse is high. It also changes the pins to opposite values in the middle of a period. It then judges both the period in progress and the following period by counting input cycles between pulses. A wrong capture point shows up as a period of the wrong length. A broken inversion of the mode term shows up as a swapped 47/48 or 32/33 result.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

  localparam int unsigned PSCL_DEF_STAGES = 4;

  typedef struct packed {
    logic band;
    logic modc;
  } pscl_sel_t;

  // Division ratio of one output period for a given selection
  function automatic int unsigned pscl_ratio(input logic band, input logic modc,
                                             input int unsigned nsub);
    if (band) return modc ? 3 * nsub : 3 * nsub - 1;
    else      return modc ? 2 * nsub : 2 * nsub + 1;
  endfunction

endpackage

// File: rtl/pscl_div23.sv
// Divide-by-2/3 cell: mode_two=1 gives a two-cycle sub-cycle, 0 gives three.
module pscl_div23 (
  input  logic clk,
  input  logic rst,
  input  logic mode_two,
  output logic sub_tick
);
  logic [1:0] ph_q;

  always_comb begin
    sub_tick = mode_two ? (ph_q == 2'd1) : (ph_q == 2'd2);
  end

  always_ff @(posedge clk) begin
    if (rst)           ph_q <= 2'd0;
    else if (sub_tick) ph_q <= 2'd0;
    else               ph_q <= ph_q + 2'd1;
  end
endmodule

// File: rtl/pscl_bin_chain.sv
// Fixed binary chain of toggle stages advanced once per sub-cycle.
module pscl_bin_chain #(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [STAGES-1:0] cnt,
  output logic              last_sub
);
  logic [STAGES-1:0] carry;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign carry[i] = adv;
    end else begin : g_next
      assign carry[i] = carry[i-1] & cnt[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst)           cnt[i] <= 1'b0;
      else if (carry[i]) cnt[i] <= ~cnt[i];
    end
  end

  assign last_sub = &cnt;
endmodule

// File: rtl/pscl_mode_ctl.sv
// Captures the selection at period boundaries and forms the 2/3 cell mode.
module pscl_mode_ctl
  import pscl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      band_sel,
  input  logic      mod_ctl,
  input  logic      cycle_end,
  input  logic      last_sub,
  output pscl_sel_t sel_q,
  output logic      mode_two
);
  logic nand_term;

  always_ff @(posedge clk) begin
    if (rst || cycle_end) begin
      sel_q.band <= band_sel;
      sel_q.modc <= mod_ctl;
    end
  end

  always_comb begin
    // Low only in the last sub-cycle of a swallow period
    nand_term = ~(last_sub & ~sel_q.modc);
    mode_two  = sel_q.band ? ~nand_term : nand_term;
  end
endmodule

// File: rtl/dualband_prescaler.sv
module dualband_prescaler
  import pscl_pkg::*;
#(
  parameter int unsigned STAGES = PSCL_DEF_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic band_sel,
  input  logic mod_ctl,
  output logic div_clk,
  output logic term_pulse
);
  logic              mode_two;
  logic              sub_tick;
  logic              last_sub;
  logic              cycle_end;
  logic [STAGES-1:0] sub_cnt;
  pscl_sel_t         sel_q;

  pscl_div23 u_div23 (
    .clk      (clk),
    .rst      (rst),
    .mode_two (mode_two),
    .sub_tick (sub_tick)
  );

  pscl_bin_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .adv      (sub_tick),
    .cnt      (sub_cnt),
    .last_sub (last_sub)
  );

  pscl_mode_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .band_sel  (band_sel),
    .mod_ctl   (mod_ctl),
    .cycle_end (cycle_end),
    .last_sub  (last_sub),
    .sel_q     (sel_q),
    .mode_two  (mode_two)
  );

  assign cycle_end  = sub_tick & last_sub;
  assign term_pulse = cycle_end;
  assign div_clk    = ~sub_cnt[STAGES-1];
endmodule

// File: rtl/dualband_prescaler_chk.sv
module dualband_prescaler_chk
  import pscl_pkg::*;
#(
  parameter int unsigned STAGES = PSCL_DEF_STAGES
) (
  input logic clk,
  input logic rst,
  input logic div_clk,
  input logic term_pulse,
  input logic band_l,
  input logic mod_l
);
  localparam int unsigned NSUB = 2 ** STAGES;
  localparam int unsigned CW   = $clog2(3 * NSUB + 2);

  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst || term_pulse) cyc_q <= '0;
    else                   cyc_q <= cyc_q + 1'b1;
  end

  assert_period_len_R2_R3_R4_R5: assert property (@(posedge clk) disable iff (rst)
    term_pulse |-> ((32'(cyc_q) + 32'd1) == pscl_ratio(band_l, mod_l, NSUB)));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    term_pulse |=> !term_pulse);

  assert_div_rise_at_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(div_clk) && !$past(rst)) |-> $past(term_pulse));

  assert_sel_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(term_pulse)) |-> ($stable(band_l) && $stable(mod_l)));
endmodule

bind dualband_prescaler dualband_prescaler_chk #(.STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .div_clk    (div_clk),
  .term_pulse (term_pulse),
  .band_l     (sel_q.band),
  .mod_l      (sel_q.modc)
);

// File: tb/dualband_prescaler_bench.sv
`timescale 1ns/1ps
module dualband_prescaler_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic band_sel = 1'b0;
  logic mod_ctl = 1'b1;
  logic div_clk, term_pulse;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    ratio;
    int    high;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  dualband_prescaler u_dualband_prescaler (
    .clk(clk), .rst(rst), .band_sel(band_sel), .mod_ctl(mod_ctl),
    .div_clk(div_clk), .term_pulse(term_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Driver: set the selection and queue the expected period result
  task automatic push_period(input logic b, input logic m, input string tag);
    exp_t e;
    band_sel = b;
    mod_ctl  = m;
    e.ratio = b ? (m ? 48 : 47) : (m ? 32 : 33);
    e.high  = b ? 24 : 16;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!term_pulse);
  endtask

  // Run one period: select at the pulse cycle, optionally disturb mid-period
  task automatic run_period(input logic b, input logic m, input bit junk, input string tag);
    push_period(b, m, tag);
    if (junk) begin
      repeat (10) @(negedge clk);
      band_sel = ~b;
      mod_ctl  = ~m;
    end
    wait_pulse();
  endtask

  // Monitor: measure each period and compare with the queue head
  int  cnt = 0;
  int  hi  = 0;
  bit  prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      cnt++;
      if (div_clk) hi++;
      if (term_pulse) begin
        chk(!prev_pulse, "R6 pulse width", prev_pulse, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected pulse", cnt, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cnt == e.ratio, {e.tag, " period"}, cnt, e.ratio);
          chk(hi == e.high, "R7 div_clk high cycles", hi, e.high);
        end
        cnt = 0;
        hi  = 0;
      end
      prev_pulse = term_pulse;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(div_clk == 1'b1, "R1 div_clk in reset", div_clk, 1);
    chk(term_pulse == 1'b0, "R1 term_pulse in reset", term_pulse, 0);
    push_period(1'b0, 1'b1, "R9 R2 first 32");
    @(posedge clk);
    #2 rst = 1'b0;
    wait_pulse();
    run_period(1'b0, 1'b0, 1'b0, "R3 R10 33");
    run_period(1'b1, 1'b1, 1'b0, "R4 R10 48");
    run_period(1'b1, 1'b0, 1'b0, "R5 R10 47");
    run_period(1'b0, 1'b1, 1'b1, "R8 R2 32 disturbed");
    run_period(1'b1, 1'b0, 1'b1, "R8 R5 47 disturbed");
    run_period(1'b0, 1'b0, 1'b1, "R8 R3 33 disturbed");
    run_period(1'b1, 1'b1, 1'b0, "R10 R4 48");
    run_period(1'b0, 1'b1, 1'b0, "R10 R2 32");
    @(negedge clk);
    chk(exp_q.size() == 0, "R6 all periods seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule